// File: doc/BRIEF.md
# Note-Indexed Square-Wave Tone Generator

This block turns a semitone index into a single-bit square wave that feeds an external headphone amplifier. A controller presents the index and an enable. While the enable is high and the index is one the block knows, the output toggles at a fixed half-period. That half-period is read from a constant divider table, which is built when the design elaborates from the clock rate and a list of equal-tempered pitches. The list starts at 415.30 Hz (index 0) and climbs one semitone per index up to 2349.32 Hz (index 30).

One voice sounds at any time. Selecting a new index abandons the current tone at once and starts the new one from a known phase. Dropping the enable, or presenting an index beyond the table, silences the output.

Top module: `tone_gen`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, wave_o is 0.
- R2: For index n (0..30), the half-period H is round(CLK_HZ / (2·f_n)) clock cycles, where f_n = 415.30 Hz · 2^(n/12). The table holds 41530, 44000, 46616, 49388, 52325, 55437, 58733, 62225, 65926, 69846, 73999, 78399, 83061, 88000, 93233, 98777, 104650, 110873, 117466, 124451, 131851, 139691, 147998, 156798, 166122, 176000, 186466, 197553, 209300, 221746 and 234932 centihertz, in index order. After a tone starts, wave_o first goes high H+1 rising clock edges after the inputs change.
- R3: While the index and the enable stay fixed, wave_o stays high for exactly H cycles and low for exactly H cycles (50% duty).
- R4: When note_en_i is low at a clock edge, wave_o is 0 after that edge and stays 0 while the enable stays low.
- R5: An index of NUM_NOTES or more (31 with the default settings) is treated as silence: wave_o is 0 from the next edge onward.
- R6: When the index changes while enabled, the tone restarts: wave_o is 0 after the next edge, even if that edge would have been a toggle, and it first rises H_new+1 edges after the change.
- R7: When the enable rises with an index that is unchanged, the tone restarts with the same timing as R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (CLK_HZ, 50 MHz by default) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| note_i | input | IDX_W (5) | Semitone index, 0 = 415.30 Hz |
| note_en_i | input | 1 | High to play note_i, low for silence |
| wave_o | output | 1 | Square-wave audio bit to the amplifier |

## Verification
Two events can land on the same edge: the divider reaching its terminal count and the index changing. The bench creates this collision deliberately. It lets a tone run through its low half until the counter sits one cycle before the toggle, and then changes the index right at that point. If the toggle took effect, the output would rise on that edge. The restart must win instead, so the output has to stay low, and its first rise has to come exactly H_new+1 edges after the change. The bench treats the collision as handled correctly only if both of those hold.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam int unsigned TABLE_NOTES = 31;

  // equal-tempered pitch in centihertz, index 0 = 415.30 Hz
  function automatic longint unsigned note_centihz(input int unsigned idx);
    case (idx)
      0:  return 41530;   1:  return 44000;   2:  return 46616;   3:  return 49388;
      4:  return 52325;   5:  return 55437;   6:  return 58733;   7:  return 62225;
      8:  return 65926;   9:  return 69846;   10: return 73999;   11: return 78399;
      12: return 83061;   13: return 88000;   14: return 93233;   15: return 98777;
      16: return 104650;  17: return 110873;  18: return 117466;  19: return 124451;
      20: return 131851;  21: return 139691;  22: return 147998;  23: return 156798;
      24: return 166122;  25: return 176000;  26: return 186466;  27: return 197553;
      28: return 209300;  29: return 221746;  30: return 234932;
      default: return 41530;
    endcase
  endfunction

  // round(clk_hz / (2 f))
  function automatic int unsigned half_count(input longint unsigned clk_hz,
                                             input int unsigned idx);
    longint unsigned f;
    f = note_centihz(idx);
    return int'((clk_hz * 100 + f) / (2 * f));
  endfunction

endpackage

// File: rtl/tone_lut.sv
module tone_lut #(
  parameter longint unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned     NUM_NOTES = 31,
  parameter int unsigned     IDX_W     = 5,
  parameter int unsigned     CNT_W     = 16
) (
  input  logic [IDX_W-1:0] note_i,
  output logic [CNT_W-1:0] half_o,
  output logic             known_o
);
  localparam int unsigned TBL_LEN = 2 ** IDX_W;

  logic [CNT_W-1:0] tbl [TBL_LEN];

  for (genvar g = 0; g < TBL_LEN; g++) begin : g_tbl
    if (g < NUM_NOTES) begin : g_note
      assign tbl[g] = CNT_W'(tone_pkg::half_count(CLK_HZ, g));
    end else begin : g_pad
      assign tbl[g] = '0;
    end
  end

  assign half_o  = tbl[note_i];
  assign known_o = {1'b0, note_i} < (IDX_W+1)'(NUM_NOTES);

endmodule

// File: rtl/tone_track.sv
module tone_track #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] note_i,
  input  logic             play_i,
  output logic             restart_o
);
  logic [IDX_W-1:0] note_q;
  logic             play_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      note_q <= '0;
      play_q <= 1'b0;
    end else begin
      note_q <= note_i;
      play_q <= play_i;
    end
  end

  // new tone: first playing cycle, or index moved
  assign restart_o = play_i && (!play_q || (note_i != note_q));

endmodule

// File: rtl/tone_counter.sv
module tone_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             play_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] half_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wave_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wave_q;
  logic             term;

  assign term = (cnt_q == half_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (!play_i || restart_i) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (term) begin
      cnt_q  <= '0;
      wave_q <= ~wave_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wave_o = wave_q;

endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
  parameter longint unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned     NUM_NOTES = 31,
  localparam int unsigned    IDX_W     = $clog2(NUM_NOTES + 1),
  localparam int unsigned    CNT_W     = $clog2(tone_pkg::half_count(CLK_HZ, 0) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] note_i,
  input  logic             note_en_i,
  output logic             wave_o
);
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt_q;
  logic             known;
  logic             play;
  logic             restart;

  tone_lut #(
    .CLK_HZ   (CLK_HZ),
    .NUM_NOTES(NUM_NOTES),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
  ) u_lut (
    .note_i (note_i),
    .half_o (half),
    .known_o(known)
  );

  assign play = note_en_i && known;

  tone_track #(
    .IDX_W(IDX_W)
  ) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .note_i   (note_i),
    .play_i   (play),
    .restart_o(restart)
  );

  tone_counter #(
    .CNT_W(CNT_W)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .play_i   (play),
    .restart_i(restart),
    .half_i   (half),
    .cnt_o    (cnt_q),
    .wave_o   (wave_o)
  );

endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
  parameter int unsigned NUM_NOTES = 31,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned CNT_W     = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] note_i,
  input logic             note_en_i,
  input logic             wave_o,
  input logic [CNT_W-1:0] cnt_i
);
  logic out_of_range;
  assign out_of_range = {1'b0, note_i} >= (IDX_W+1)'(NUM_NOTES);

  AST_SILENT_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !note_en_i |=> !wave_o); // R4

  AST_SILENT_OUT_OF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (note_en_i && out_of_range) |=> !wave_o); // R5

  AST_RESTART_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (note_en_i && (note_i != $past(note_i))) |=> !wave_o); // R6

  AST_NO_MIDCOUNT_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |-> $stable(wave_o)); // R3

endmodule

bind tone_gen tone_gen_chk #(
  .NUM_NOTES(NUM_NOTES),
  .IDX_W    (IDX_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .note_i   (note_i),
  .note_en_i(note_en_i),
  .wave_o   (wave_o),
  .cnt_i    (cnt_q)
);

// File: tb/tone_gen_tb.sv
module tone_gen_tb;
  localparam longint unsigned CLK_HZ = 500_000;
  localparam int NUM = 31;
  localparam int NV  = 6;
  localparam int VEC_IDX  [NV] = '{0, 30, 1, 12, 25, 7};
  localparam int VEC_HALF [NV] = '{602, 106, 568, 301, 142, 402};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       note_en = 1'b0;
  logic [4:0] note = '0;
  logic       wave;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tone_gen #(.CLK_HZ(CLK_HZ), .NUM_NOTES(NUM)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .note_i   (note),
    .note_en_i(note_en),
    .wave_o   (wave)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
    end while (wave !== lvl && n < 4000);
  endtask

  task automatic count_highs(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); @(negedge clk);
      if (wave !== 1'b0) highs++;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int h;
    repeat (3) @(negedge clk);
    check(wave === 1'b0, "R1 reset", int'(wave), 0);
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk);
    check(wave === 1'b0, "R1 after release", int'(wave), 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      note = 5'(VEC_IDX[v]); note_en = 1'b1;
      edges_until(1'b1, n);
      check(n == VEC_HALF[v] + 1, "R2 first rise", n, VEC_HALF[v] + 1);
      edges_until(1'b0, n);
      check(n == VEC_HALF[v], "R3 high time", n, VEC_HALF[v]);
      edges_until(1'b1, n);
      check(n == VEC_HALF[v], "R3 low time", n, VEC_HALF[v]);
    end

    // R6: index change on the low-phase terminal-count edge (index 7, H=402)
    edges_until(1'b0, n);
    repeat (401) begin @(posedge clk); @(negedge clk); end
    note = 5'd30;
    @(posedge clk); @(negedge clk);
    check(wave === 1'b0, "R6 toggle suppressed", int'(wave), 0);
    edges_until(1'b1, n);
    check(n == 106, "R6 restart rise", n + 1, 107);

    // R4: drop enable while high
    note_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check(wave === 1'b0, "R4 off next edge", int'(wave), 0);
    count_highs(800, h);
    check(h == 0, "R4 stays silent", h, 0);

    // R7: enable again, same index
    note_en = 1'b1;
    edges_until(1'b1, n);
    check(n == 107, "R7 re-enable rise", n, 107);

    // R5: index beyond table
    note = 5'd31;
    @(posedge clk); @(negedge clk);
    check(wave === 1'b0, "R5 out of range", int'(wave), 0);
    count_highs(800, h);
    check(h == 0, "R5 stays silent", h, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule